// File: doc/BRIEF.md
# Microcoded Control Sequencer with Split Next-State Memories

This block is the control unit of a small multicycle processor. A 6-bit state register addresses a main control memory. Each 25-bit word of that memory supplies the datapath control signals for the current state and a proposed next state. Two small memories sit beside it. The dispatch memory turns the instruction's 3-bit opcode into the first state of that instruction. The branch memory turns the zero flag into the taken or the not-taken continuation of a compare-and-branch.

Two test bits in the control word decide which source loads the state register. The zero flag therefore never forms part of the main memory address, and that memory needs only one word per state. All three memories are parameters fixed at elaboration.

A single-step mode lets a debugger walk the microprogram one state per step pulse. If both test bits are set in one word, the sequencer stops and reports the fault instead of loading an undefined value.

Top module: `mseq_top`

## Requirements
- R1: While rst_n is low, the state is 0. ctrl then shows bits 22..6 of main word 0, and conflict_err shows 0 unless word 0 has both test bits set.
- R2: After rst_n rises, the state stays 0 across the first two rising clock edges. It can first change on the third edge.
- R3: A main word has bits 5..0 as the next-state field, bit 23 as the opcode-test bit and bit 24 as the zero-test bit. When both test bits are 0, an advancing edge loads the next-state field.
- R4: When only bit 23 is set, an advancing edge loads the 6-bit dispatch entry selected by opcode. Entry k occupies bits 6k+5..6k of the dispatch parameter.
- R5: When only bit 24 is set, an advancing edge loads branch entry z_flag, where entry 1 is the taken path. The branch memory has four 6-bit entries, and the upper address bit is always 0, so entries 2 and 3 are never used.
- R6: When bits 23 and 24 are both set, conflict_err is 1 and the state holds on every edge until reset.
- R7: With step_mode high, the state advances only on an edge where step is 1 and step was 0 at the previous edge. Holding step high gives exactly one advance.
- R8: ctrl always equals bits 22..6 of the main word of the current state, with word bit 6 on ctrl[0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| step_mode | input | 1 | 1 selects single-step operation |
| step | input | 1 | Step request; its rising edge advances one state in step mode |
| opcode | input | 3 | Opcode of the current instruction, used for dispatch |
| z_flag | input | 1 | Zero flag from the datapath, used for branch resolution |
| ctrl | output | 17 | Datapath control signals, main word bits 22..6 |
| conflict_err | output | 1 | Both next-state tests set in the current word |

## Verification
Every state drives a distinct ctrl pattern, so a wrong state shows at ctrl on the very edge it is loaded. A mis-chosen next-state source shows half a cycle later, at the next falling-edge sample. A bad step gate or a bad release counter shows as a state change one edge early or one edge late. A failed conflict hold shows as ctrl moving while conflict_err is high.

// File: rtl/mseq_pkg.sv
package mseq_pkg;
  localparam int ST_W     = 6;
  localparam int OP_W     = 3;
  localparam int ZA_W     = 2;
  localparam int CW_W     = 25;
  localparam int NS_LSB   = 0;
  localparam int DP_LSB   = 6;
  localparam int DP_W     = 17;
  localparam int OPT_BIT  = 23;
  localparam int CHKZ_BIT = 24;
  localparam int N_ST     = 1 << ST_W;
  localparam int N_OP     = 1 << OP_W;
  localparam int N_Z      = 1 << ZA_W;

  typedef enum logic [1:0] {
    SRC_FIELD = 2'b00,
    SRC_DISP  = 2'b01,
    SRC_ZERO  = 2'b10,
    SRC_NONE  = 2'b11
  } nsrc_e;

  function automatic logic [N_ST*CW_W-1:0] dflt_main();
    logic [N_ST*CW_W-1:0] img;
    logic [CW_W-1:0]      w;
    img = '0;
    for (int s = 0; s < N_ST; s++) begin
      w = '0;
      w[NS_LSB +: ST_W] = ST_W'((s + 1) % N_ST);
      w[DP_LSB +: DP_W] = DP_W'(s * 1031 + 7);
      w[OPT_BIT]        = (s == 2);
      w[CHKZ_BIT]       = (s == 11);
      img[s*CW_W +: CW_W] = w;
    end
    return img;
  endfunction

  function automatic logic [N_OP*ST_W-1:0] dflt_disp();
    logic [N_OP*ST_W-1:0] img;
    for (int k = 0; k < N_OP; k++) img[k*ST_W +: ST_W] = ST_W'(4 + k);
    return img;
  endfunction

  function automatic logic [N_Z*ST_W-1:0] dflt_zero();
    logic [N_Z*ST_W-1:0] img;
    img = '0;
    img[0 +: ST_W]    = ST_W'(12);
    img[ST_W +: ST_W] = ST_W'(20);
    return img;
  endfunction
endpackage

// File: rtl/mseq_rom.sv
module mseq_rom #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 6,
  parameter int AW    = $clog2(DEPTH),
  parameter logic [DEPTH*WIDTH-1:0] INIT = '0
) (
  input  logic [AW-1:0]    addr,
  output logic [WIDTH-1:0] data
);
  logic [WIDTH-1:0] mem [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    assign mem[i] = INIT[i*WIDTH +: WIDTH];
  end

  assign data = mem[addr];
endmodule

// File: rtl/mseq_nsel.sv
module mseq_nsel
  import mseq_pkg::*;
(
  input  logic [ST_W-1:0] cur_state,
  input  logic [ST_W-1:0] field_state,
  input  logic [ST_W-1:0] disp_state,
  input  logic [ST_W-1:0] zero_state,
  input  logic            opt_test,
  input  logic            chk_zero,
  output logic [ST_W-1:0] nxt_state,
  output logic            conflict
);
  nsrc_e src;

  always_comb begin
    src       = nsrc_e'({chk_zero, opt_test});
    conflict  = 1'b0;
    nxt_state = field_state;
    unique case (src)
      SRC_FIELD: nxt_state = field_state;
      SRC_DISP:  nxt_state = disp_state;
      SRC_ZERO:  nxt_state = zero_state;
      SRC_NONE: begin
        nxt_state = cur_state;
        conflict  = 1'b1;
      end
      default:   nxt_state = field_state;
    endcase
  end
endmodule

// File: rtl/mseq_state.sv
module mseq_state
  import mseq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            step_mode,
  input  logic            step,
  input  logic [ST_W-1:0] nxt_state,
  output logic [ST_W-1:0] state_q,
  output logic            adv
);
  logic            sync1_q;
  logic            run_q;
  logic            step_d_q;
  logic            step_pulse;
  logic [ST_W-1:0] state_d;

  always_comb begin
    step_pulse = step & ~step_d_q;
    adv        = run_q & (~step_mode | step_pulse);
    state_d    = adv ? nxt_state : state_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q  <= 1'b0;
      run_q    <= 1'b0;
      step_d_q <= 1'b0;
      state_q  <= '0;
    end else begin
      sync1_q  <= 1'b1;
      run_q    <= sync1_q;
      step_d_q <= step;
      state_q  <= state_d;
    end
  end

  assert_release_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |=> $stable(state_q))
    else $error("R2 state moved before reset release completed");

  assert_step_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (step_mode && !(step && !step_d_q)) |=> $stable(state_q))
    else $error("R7 state moved in step mode without a step edge");
endmodule

// File: rtl/mseq_top.sv
module mseq_top
  import mseq_pkg::*;
#(
  parameter logic [N_ST*CW_W-1:0] MAIN_INIT = dflt_main(),
  parameter logic [N_OP*ST_W-1:0] DISP_INIT = dflt_disp(),
  parameter logic [N_Z*ST_W-1:0]  ZERO_INIT = dflt_zero()
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            step_mode,
  input  logic            step,
  input  logic [2:0]      opcode,
  input  logic            z_flag,
  output logic [16:0]     ctrl,
  output logic            conflict_err
);
  logic [ST_W-1:0] state_q;
  logic [ST_W-1:0] nxt_state;
  logic [ST_W-1:0] disp_data;
  logic [ST_W-1:0] zero_data;
  logic [CW_W-1:0] word;
  logic [ZA_W-1:0] zaddr;
  logic            adv;
  logic            opt_test;
  logic            chk_zero;

  assign zaddr = {{(ZA_W-1){1'b0}}, z_flag};

  mseq_rom #(.DEPTH(N_ST), .WIDTH(CW_W), .INIT(MAIN_INIT)) u_main (
    .addr(state_q), .data(word));

  mseq_rom #(.DEPTH(N_OP), .WIDTH(ST_W), .INIT(DISP_INIT)) u_disp (
    .addr(opcode), .data(disp_data));

  mseq_rom #(.DEPTH(N_Z), .WIDTH(ST_W), .INIT(ZERO_INIT)) u_zero (
    .addr(zaddr), .data(zero_data));

  assign opt_test = word[OPT_BIT];
  assign chk_zero = word[CHKZ_BIT];

  mseq_nsel u_nsel (
    .cur_state  (state_q),
    .field_state(word[NS_LSB +: ST_W]),
    .disp_state (disp_data),
    .zero_state (zero_data),
    .opt_test   (opt_test),
    .chk_zero   (chk_zero),
    .nxt_state  (nxt_state),
    .conflict   (conflict_err)
  );

  mseq_state u_state (
    .clk      (clk),
    .rst_n    (rst_n),
    .step_mode(step_mode),
    .step     (step),
    .nxt_state(nxt_state),
    .state_q  (state_q),
    .adv      (adv)
  );

  assign ctrl = word[DP_LSB +: DP_W];

  assert_field_next_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !opt_test && !chk_zero) |=> state_q == $past(word[NS_LSB +: ST_W]))
    else $error("R3 next-state field not loaded");

  assert_dispatch_next_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && opt_test && !chk_zero) |=> state_q == $past(disp_data))
    else $error("R4 dispatch entry not loaded");

  assert_zero_next_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && chk_zero && !opt_test) |=> state_q == $past(zero_data))
    else $error("R5 branch entry not loaded");

  assert_conflict_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    conflict_err |=> $stable(state_q))
    else $error("R6 state moved during test conflict");
endmodule

// File: tb/sim_mseq_top.sv
`timescale 1ns/1ps
module sim_mseq_top;
  localparam int CLK_HALF = 4;

  function automatic logic [64*25-1:0] tb_main_img();
    logic [64*25-1:0] img;
    logic [24:0]      w;
    for (int s = 0; s < 64; s++) begin
      w = '0;
      w[5:0]  = (s == 25) ? 6'd0 : 6'((s + 1) % 64);
      w[22:6] = {5'(s) ^ 5'h15, 6'(s), ~6'(s)};
      w[23]   = (s == 3) || (s == 50);
      w[24]   = (s == 14) || (s == 50);
      img[s*25 +: 25] = w;
    end
    return img;
  endfunction

  function automatic logic [8*6-1:0] tb_disp_img();
    logic [8*6-1:0] img;
    for (int k = 0; k < 8; k++) img[k*6 +: 6] = 6'(6 + k);
    return img;
  endfunction

  localparam logic [64*25-1:0] MAIN_P = tb_main_img();
  localparam logic [8*6-1:0]   DISP_P = tb_disp_img();
  localparam logic [4*6-1:0]   ZERO_P = {6'd63, 6'd63, 6'd20, 6'd40};

  logic        clk = 1'b0;
  logic        rst_n;
  logic        step_mode;
  logic        step;
  logic [2:0]  opcode;
  logic        z_flag;
  logic [16:0] ctrl;
  logic        conflict_err;

  int tests_run = 0;
  int tests_failed = 0;

  always #(CLK_HALF) clk = ~clk;

  mseq_top #(.MAIN_INIT(MAIN_P), .DISP_INIT(DISP_P), .ZERO_INIT(ZERO_P)) u0 (
    .clk(clk), .rst_n(rst_n), .step_mode(step_mode), .step(step),
    .opcode(opcode), .z_flag(z_flag), .ctrl(ctrl), .conflict_err(conflict_err));

  int    m_st;
  bit    m_s1, m_run, m_sd;
  string m_kind;

  always @(negedge rst_n) begin
    m_st = 0; m_s1 = 0; m_run = 0; m_sd = 0; m_kind = "R1";
  end

  always @(posedge clk) begin
    if (rst_n) begin
      logic [24:0] w;
      bit pulse, go;
      w     = MAIN_P[m_st*25 +: 25];
      pulse = step && !m_sd;
      go    = m_run && (!step_mode || pulse);
      if (!m_run)              m_kind = "R2";
      else if (w[23] && w[24]) m_kind = "R6";
      else if (!go)            m_kind = "R7";
      else if (w[23]) begin m_st = int'(DISP_P[opcode*6 +: 6]); m_kind = step_mode ? "R7" : "R4"; end
      else if (w[24]) begin m_st = int'(ZERO_P[int'(z_flag)*6 +: 6]); m_kind = step_mode ? "R7" : "R5"; end
      else            begin m_st = int'(w[5:0]); m_kind = step_mode ? "R7" : "R3"; end
      m_run = m_s1;
      m_s1  = 1'b1;
      m_sd  = step;
    end
  end

  task automatic check_now();
    logic [24:0] w;
    w = MAIN_P[m_st*25 +: 25];
    tests_run++;
    if (ctrl !== w[22:6]) begin
      tests_failed++;
      $display("FAIL %s R8 ctrl actual=%h expected=%h (model state %0d)", m_kind, ctrl, w[22:6], m_st);
    end
    tests_run++;
    if (conflict_err !== (w[23] & w[24])) begin
      tests_failed++;
      $display("FAIL %s R6 conflict_err actual=%b expected=%b", m_kind, conflict_err, w[23] & w[24]);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
      check_now();
    end
  endtask

  initial begin
    #(CLK_HALF * 2 * 200000);
    tests_run++;
    tests_failed++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  end

  initial begin
    rst_n = 1'b0; step_mode = 1'b0; step = 1'b0; opcode = 3'd0; z_flag = 1'b1;
    #1;
    check_now();                     // R1 during reset
    cyc(3);
    rst_n = 1'b1;                    // released at a falling edge
    cyc(3);                          // R2: two held edges, then first advance
    for (int op = 0; op < 8; op++) begin
      opcode = 3'(op);               // R4 dispatch per opcode, R5 taken path, R3 fields
      cyc(24);
    end
    step_mode = 1'b1;                // R7
    cyc(5);
    step = 1'b1;
    cyc(3);
    step = 1'b0;
    cyc(2);
    for (int p = 0; p < 12; p++) begin
      step = 1'b1; cyc(1);
      step = 1'b0; cyc(1);
    end
    step_mode = 1'b0;
    z_flag = 1'b0;                   // R5 not-taken path leading to the R6 conflict state
    cyc(70);
    rst_n = 1'b0;                    // R1 asynchronous reset mid-run
    #1;
    check_now();
    cyc(2);
    rst_n = 1'b1;                    // R2 again
    z_flag = 1'b1;
    opcode = 3'd5;
    cyc(30);
    $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  end
endmodule